// File: doc/BRIEF.md
# Serial NOR Page-Program Write Engine

This block programs a serial NOR flash page from a simple register interface. It has two data paths. In staged mode, software switches on a 128-byte staging buffer, fills it through a 32-bit push port and then starts a write. The engine sends the program opcode, the address and every staged byte inside one chip-select window. In single-byte mode, the same start bit sends the opcode, the address and one byte taken from a byte register.

Around the program window, the engine can also send a write-enable command in its own window before the program. After the program it can keep reading the flash status register until the busy flag clears. Either step can be switched off through configuration bits. All traffic uses one data line in SPI mode 0, with SCK running at half the core clock.

Register map (3-bit offset, write strobe, combinational read): 0 command (bit 4 start/busy); 1 buffer configuration (bit 0 staging enable, bit 4 custom opcode enable); 2 sequence configuration (bit 7 suppress write-enable, bit 5 suppress status polling); 3 opcode slot [7:0]; 4 address [31:0]; 5 address mode (bit 4 four-byte address); 6 single data byte [7:0]; 7 push port (write only, reads 0).

Top module: `nor_pp_wr_engine`

## Requirements
- R1: After reset, chip select is high, SCK is low, and the command and buffer configuration registers read 0.
- R2: Bit 0 of the buffer configuration register reads back the staging state that is actually in force. A change written while a write is in progress takes effect only after that write ends, so software polls the bit until it matches.
- R3: With staging on and the buffer full, a write sends exactly 128 data bytes. Each pushed word goes out byte [7:0] first, then [15:8], then [23:16], then [31:24], and words go out in push order.
- R4: Words pushed after 128 bytes are staged are discarded.
- R5: The staging fill point returns to empty whenever staging goes from off to on.
- R6: A write started with staging on but the buffer not full sends only the bytes pushed so far.
- R7: With staging off, a write sends one data byte, the low byte of register 6.
- R8: The opcode is 0x02 unless bit 4 of register 1 is set, in which case it comes from register 3. The address follows MSB first, as 3 bytes, or 4 bytes when bit 4 of register 5 is set.
- R9: Unless bit 7 of register 2 is set, a one-byte window carrying 0x06 comes before the program window.
- R10: Unless bit 5 of register 2 is set, the engine sends two-byte windows (0x05, then a read byte) after the program. It repeats them until the bit 0 it reads is 0.
- R11: Command bit 4 reads 1 from the cycle after it is written until the whole sequence ends, and then clears by itself. Writing it while it reads 1 starts nothing.
- R12: SPI mode 0 on one line: SCK is low whenever chip select is high. The opcode, address and all data bytes of a program share one chip-select low window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The hardest case to reach is a staging-enable change that arrives while a write is in flight. The readback has to show the old state, and the new state has to apply only once the status polling finishes. The bench reaches this case by making its flash model report busy for several polls, which stretches the sequence, and it writes the configuration and a second start request during that time. The overflow and fill-point reset cases are reached by pushing extra words past a full buffer and then refilling it after toggling staging off and on.

// File: rtl/nor_pp_pkg.sv
package nor_pp_pkg;
  localparam logic [7:0] OPC_WREN    = 8'h06;
  localparam logic [7:0] OPC_RDSTAT  = 8'h05;
  localparam logic [7:0] OPC_PP_DEF  = 8'h02;

  typedef enum logic [2:0] {
    RA_CMD   = 3'd0,
    RA_BCFG  = 3'd1,
    RA_SCFG  = 3'd2,
    RA_OPC   = 3'd3,
    RA_ADDR  = 3'd4,
    RA_AMODE = 3'd5,
    RA_WBYTE = 3'd6,
    RA_PUSH  = 3'd7
  } reg_addr_e;

  localparam int CMD_WR_BIT     = 4;
  localparam int BCFG_STAGE_BIT = 0;
  localparam int BCFG_CUST_BIT  = 4;
  localparam int SCFG_NOWEN_BIT = 7;
  localparam int SCFG_NOPOL_BIT = 5;
  localparam int AMODE_4B_BIT   = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_WEN, S_GAP_W, S_OP, S_ADR, S_DAT, S_GAP_P, S_POLL_OP, S_POLL_RX
  } seq_state_e;
endpackage

// File: rtl/nor_pp_regs.sv
module nor_pp_regs
  import nor_pp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  input  logic        busy,
  output logic [31:0] rdata,
  output logic        start,
  output logic        stage_on,
  output logic        stage_clr,
  output logic        push,
  output logic        cust_op,
  output logic [7:0]  opc,
  output logic [31:0] flash_addr,
  output logic        four_b,
  output logic [7:0]  wbyte,
  output logic        no_wen,
  output logic        no_poll
);
  logic        stage_req_q, stage_req_d;
  logic        stage_on_q, stage_on_d;
  logic        cust_q, cust_d;
  logic        nowen_q, nowen_d;
  logic        nopol_q, nopol_d;
  logic [7:0]  opc_q, opc_d;
  logic [31:0] addr_q, addr_d;
  logic        fourb_q, fourb_d;
  logic [7:0]  wbyte_q, wbyte_d;
  logic        apply_ok;

  assign start     = wr && (addr == RA_CMD) && wdata[CMD_WR_BIT] && !busy;
  assign apply_ok  = !busy && !start;
  assign stage_clr = apply_ok && stage_req_q && !stage_on_q;
  assign push      = wr && (addr == RA_PUSH) && stage_on_q && !busy;

  always_comb begin
    stage_req_d = stage_req_q;
    cust_d      = cust_q;
    nowen_d     = nowen_q;
    nopol_d     = nopol_q;
    opc_d       = opc_q;
    addr_d      = addr_q;
    fourb_d     = fourb_q;
    wbyte_d     = wbyte_q;
    stage_on_d  = apply_ok ? stage_req_q : stage_on_q;
    if (wr) begin
      case (addr)
        RA_BCFG: begin
          stage_req_d = wdata[BCFG_STAGE_BIT];
          cust_d      = wdata[BCFG_CUST_BIT];
        end
        RA_SCFG: begin
          nowen_d = wdata[SCFG_NOWEN_BIT];
          nopol_d = wdata[SCFG_NOPOL_BIT];
        end
        RA_OPC:   opc_d   = wdata[7:0];
        RA_ADDR:  addr_d  = wdata;
        RA_AMODE: fourb_d = wdata[AMODE_4B_BIT];
        RA_WBYTE: wbyte_d = wdata[7:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_req_q <= 1'b0;
      stage_on_q  <= 1'b0;
      cust_q      <= 1'b0;
      nowen_q     <= 1'b0;
      nopol_q     <= 1'b0;
      opc_q       <= 8'h00;
      addr_q      <= 32'h0;
      fourb_q     <= 1'b0;
      wbyte_q     <= 8'h00;
    end else begin
      stage_req_q <= stage_req_d;
      stage_on_q  <= stage_on_d;
      cust_q      <= cust_d;
      nowen_q     <= nowen_d;
      nopol_q     <= nopol_d;
      opc_q       <= opc_d;
      addr_q      <= addr_d;
      fourb_q     <= fourb_d;
      wbyte_q     <= wbyte_d;
    end
  end

  always_comb begin
    rdata = 32'h0;
    case (addr)
      RA_CMD:   rdata[CMD_WR_BIT] = busy;
      RA_BCFG: begin
        rdata[BCFG_STAGE_BIT] = stage_on_q;
        rdata[BCFG_CUST_BIT]  = cust_q;
      end
      RA_SCFG: begin
        rdata[SCFG_NOWEN_BIT] = nowen_q;
        rdata[SCFG_NOPOL_BIT] = nopol_q;
      end
      RA_OPC:   rdata[7:0] = opc_q;
      RA_ADDR:  rdata      = addr_q;
      RA_AMODE: rdata[AMODE_4B_BIT] = fourb_q;
      RA_WBYTE: rdata[7:0] = wbyte_q;
      default:  rdata = 32'h0;
    endcase
  end

  assign stage_on   = stage_on_q;
  assign cust_op    = cust_q;
  assign opc        = opc_q;
  assign flash_addr = addr_q;
  assign four_b     = fourb_q;
  assign wbyte      = wbyte_q;
  assign no_wen     = nowen_q;
  assign no_poll    = nopol_q;
endmodule

// File: rtl/nor_pp_stage_buf.sv
module nor_pp_stage_buf #(
  parameter int PAGE_BYTES = 128,
  localparam int WORDS = PAGE_BYTES / 4,
  localparam int PW    = $clog2(WORDS + 1),
  localparam int IW    = $clog2(PAGE_BYTES),
  localparam int CW    = $clog2(PAGE_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [31:0]   push_data,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_byte,
  output logic [CW-1:0] fill_bytes
);
  logic [PW-1:0] wptr_q, wptr_d;
  logic [31:0]   words [WORDS];
  logic [31:0]   sel_word;
  logic          full;

  assign full = (wptr_q == PW'(WORDS));

  always_comb begin
    wptr_d = wptr_q;
    if (clr)
      wptr_d = '0;
    else if (push && !full)
      wptr_d = wptr_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wptr_q <= '0;
    else        wptr_q <= wptr_d;
  end

  for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
    always_ff @(posedge clk) begin
      if (push && !clr && (wptr_q == PW'(gi)))
        words[gi] <= push_data;
    end
  end

  assign sel_word   = words[rd_idx[IW-1:2]];
  assign rd_byte    = sel_word[{rd_idx[1:0], 3'b000} +: 8];
  assign fill_bytes = CW'({wptr_q, 2'b00});
endmodule

// File: rtl/nor_pp_shifter.sv
module nor_pp_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       busy,
  output logic       done,
  output logic       rx_last,
  output logic       sck,
  output logic       mosi
);
  logic       act_q, act_d;
  logic       ph_q, ph_d;
  logic [7:0] sr_q, sr_d;
  logic [3:0] cnt_q, cnt_d;
  logic       done_q, done_d;
  logic       rx_q, rx_d;

  always_comb begin
    act_d  = act_q;
    ph_d   = ph_q;
    sr_d   = sr_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    rx_d   = rx_q;
    if (!act_q) begin
      if (go) begin
        act_d = 1'b1;
        ph_d  = 1'b0;
        sr_d  = tx;
        cnt_d = 4'd8;
      end
    end else if (!ph_q) begin
      ph_d = 1'b1;
    end else begin
      ph_d  = 1'b0;
      rx_d  = miso;
      sr_d  = {sr_q[6:0], 1'b0};
      cnt_d = cnt_q - 4'd1;
      if (cnt_q == 4'd1) begin
        act_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      ph_q   <= 1'b0;
      sr_q   <= 8'h00;
      cnt_q  <= 4'd0;
      done_q <= 1'b0;
      rx_q   <= 1'b0;
    end else begin
      act_q  <= act_d;
      ph_q   <= ph_d;
      sr_q   <= sr_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      rx_q   <= rx_d;
    end
  end

  assign busy    = act_q;
  assign done    = done_q;
  assign rx_last = rx_q;
  assign sck     = act_q & ph_q;
  assign mosi    = sr_q[7];
endmodule

// File: rtl/nor_pp_seq.sv
module nor_pp_seq
  import nor_pp_pkg::*;
#(
  parameter int PAGE_BYTES = 128,
  parameter int GAP_CYC    = 2,
  localparam int IW = $clog2(PAGE_BYTES),
  localparam int CW = $clog2(PAGE_BYTES + 1),
  localparam int GW = $clog2(GAP_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stage_on,
  input  logic [CW-1:0] fill_bytes,
  input  logic [7:0]    stage_byte,
  input  logic          cust_op,
  input  logic [7:0]    opc,
  input  logic [31:0]   flash_addr,
  input  logic          four_b,
  input  logic [7:0]    wbyte,
  input  logic          no_wen,
  input  logic          no_poll,
  input  logic          sh_busy,
  input  logic          sh_done,
  input  logic          sh_rx_last,
  output logic          busy,
  output logic          cs_n,
  output logic          sh_go,
  output logic [7:0]    sh_tx,
  output logic [IW-1:0] stage_idx
);
  seq_state_e    st_q, st_d;
  logic [CW-1:0] idx_q, idx_d;
  logic [GW-1:0] gap_q, gap_d;
  logic          cs_n_q;
  logic [CW-1:0] n_adr, n_dat;
  logic [1:0]    adr_sel;
  seq_state_e    after_dat;

  function automatic logic cs_active(seq_state_e s);
    return (s == S_WEN) || (s == S_OP) || (s == S_ADR) || (s == S_DAT) ||
           (s == S_POLL_OP) || (s == S_POLL_RX);
  endfunction

  assign n_adr     = four_b ? CW'(4) : CW'(3);
  assign n_dat     = stage_on ? fill_bytes : CW'(1);
  assign after_dat = no_poll ? S_IDLE : S_GAP_P;
  assign adr_sel   = 2'(n_adr - CW'(1) - idx_q);

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    gap_d = gap_q;
    case (st_q)
      S_IDLE: if (start) begin
        st_d  = no_wen ? S_OP : S_WEN;
        idx_d = '0;
      end
      S_WEN: if (sh_done) begin
        st_d  = S_GAP_W;
        gap_d = '0;
      end
      S_GAP_W: begin
        gap_d = gap_q + GW'(1);
        if (gap_q == GW'(GAP_CYC - 1)) st_d = S_OP;
      end
      S_OP: if (sh_done) begin
        st_d  = S_ADR;
        idx_d = '0;
      end
      S_ADR: if (sh_done) begin
        if (idx_q == n_adr - CW'(1)) begin
          idx_d = '0;
          gap_d = '0;
          st_d  = (n_dat == '0) ? after_dat : S_DAT;
        end else begin
          idx_d = idx_q + CW'(1);
        end
      end
      S_DAT: if (sh_done) begin
        if (idx_q == n_dat - CW'(1)) begin
          st_d  = after_dat;
          gap_d = '0;
        end else begin
          idx_d = idx_q + CW'(1);
        end
      end
      S_GAP_P: begin
        gap_d = gap_q + GW'(1);
        if (gap_q == GW'(GAP_CYC - 1)) st_d = S_POLL_OP;
      end
      S_POLL_OP: if (sh_done) st_d = S_POLL_RX;
      S_POLL_RX: if (sh_done) begin
        gap_d = '0;
        st_d  = sh_rx_last ? S_GAP_P : S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      idx_q  <= '0;
      gap_q  <= '0;
      cs_n_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      gap_q  <= gap_d;
      cs_n_q <= !cs_active(st_d);
    end
  end

  always_comb begin
    case (st_q)
      S_WEN:     sh_tx = OPC_WREN;
      S_OP:      sh_tx = cust_op ? opc : OPC_PP_DEF;
      S_ADR: begin
        case (adr_sel)
          2'd3:    sh_tx = flash_addr[31:24];
          2'd2:    sh_tx = flash_addr[23:16];
          2'd1:    sh_tx = flash_addr[15:8];
          default: sh_tx = flash_addr[7:0];
        endcase
      end
      S_DAT:     sh_tx = stage_on ? stage_byte : wbyte;
      S_POLL_OP: sh_tx = OPC_RDSTAT;
      default:   sh_tx = 8'h00;
    endcase
  end

  assign sh_go     = cs_active(st_q) && !sh_busy && !sh_done;
  assign busy      = (st_q != S_IDLE);
  assign cs_n      = cs_n_q;
  assign stage_idx = idx_q[IW-1:0];
endmodule

// File: rtl/nor_pp_wr_engine.sv
module nor_pp_wr_engine #(
  parameter int PAGE_BYTES = 128,
  parameter int GAP_CYC    = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_cs_n,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int IW = $clog2(PAGE_BYTES);
  localparam int CW = $clog2(PAGE_BYTES + 1);

  logic [1:0]    rst_sync_q;
  logic          rst_sync_n;
  logic          eng_busy, start, stage_on, stage_clr, push;
  logic          cust_op, four_b, no_wen, no_poll;
  logic [7:0]    opc, wbyte, stage_byte, sh_tx;
  logic [31:0]   flash_addr;
  logic [CW-1:0] fill_bytes;
  logic [IW-1:0] stage_idx;
  logic          sh_go, sh_busy, sh_done, sh_rx_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  nor_pp_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .busy(eng_busy), .rdata(reg_rdata), .start(start),
    .stage_on(stage_on), .stage_clr(stage_clr), .push(push),
    .cust_op(cust_op), .opc(opc), .flash_addr(flash_addr), .four_b(four_b),
    .wbyte(wbyte), .no_wen(no_wen), .no_poll(no_poll)
  );

  nor_pp_stage_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_sync_n), .clr(stage_clr), .push(push),
    .push_data(reg_wdata), .rd_idx(stage_idx), .rd_byte(stage_byte),
    .fill_bytes(fill_bytes)
  );

  nor_pp_seq #(.PAGE_BYTES(PAGE_BYTES), .GAP_CYC(GAP_CYC)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .start(start), .stage_on(stage_on),
    .fill_bytes(fill_bytes), .stage_byte(stage_byte), .cust_op(cust_op),
    .opc(opc), .flash_addr(flash_addr), .four_b(four_b), .wbyte(wbyte),
    .no_wen(no_wen), .no_poll(no_poll), .sh_busy(sh_busy),
    .sh_done(sh_done), .sh_rx_last(sh_rx_last), .busy(eng_busy),
    .cs_n(spi_cs_n), .sh_go(sh_go), .sh_tx(sh_tx), .stage_idx(stage_idx)
  );

  nor_pp_shifter u_sh (
    .clk(clk), .rst_n(rst_sync_n), .go(sh_go), .tx(sh_tx), .miso(spi_miso),
    .busy(sh_busy), .done(sh_done), .rx_last(sh_rx_last), .sck(spi_sck),
    .mosi(spi_mosi)
  );
endmodule

// File: rtl/nor_pp_chk.sv
module nor_pp_chk #(
  parameter int PAGE_BYTES = 128,
  localparam int CW = $clog2(PAGE_BYTES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          sck,
  input logic          busy,
  input logic          sh_busy,
  input logic          stage_on,
  input logic [CW-1:0] fill_bytes
);
  p_sck_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  p_cs_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sh_busy |-> !cs_n);
  p_idle_cs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_bytes <= CW'(PAGE_BYTES));
  p_fill_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stage_on) |-> (fill_bytes == '0));
  p_stage_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(stage_on));
endmodule

bind nor_pp_wr_engine nor_pp_chk #(.PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cs_n(spi_cs_n), .sck(spi_sck),
  .busy(eng_busy), .sh_busy(sh_busy), .stage_on(stage_on),
  .fill_bytes(fill_bytes)
);

// File: tb/tb_nor_pp_wr_engine.sv
module tb_nor_pp_wr_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        spi_cs_n, spi_sck, spi_mosi;
  logic        spi_miso;

  always #4 clk = ~clk;

  nor_pp_wr_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int checks = 0;
  int errors = 0;

  // flash model: records every chip-select window
  int         wcount = 0;
  int         cur = 0;
  logic [7:0] wb [0:15][0:139];
  int         wl [0:15];
  logic [7:0] sh = 8'h00;
  int         nbit = 0;
  int         nfall = 0;
  int         busy_left = 0;
  logic [7:0] stat_cur = 8'h00;
  int         sck_bad = 0;

  always @(negedge spi_cs_n) begin
    cur = wcount;
    wcount++;
    if (cur < 16) wl[cur] = 0;
    nbit = 0;
    nfall = 0;
    stat_cur = (busy_left > 0) ? 8'h01 : 8'h00;
  end

  always @(posedge spi_cs_n) begin
    if (cur < 16 && wl[cur] >= 2 && wb[cur][0] == 8'h05 && busy_left > 0)
      busy_left--;
  end

  always @(posedge spi_sck) begin
    if (spi_cs_n) sck_bad++;
    sh = {sh[6:0], spi_mosi};
    nbit++;
    if (nbit % 8 == 0 && cur < 16 && wl[cur] < 140) begin
      wb[cur][wl[cur]] = sh;
      wl[cur]++;
    end
  end

  always @(negedge spi_sck) nfall++;

  always @* begin
    if (nfall >= 8 && nfall < 16) spi_miso = stat_cur[15 - nfall];
    else spi_miso = 1'b0;
  end

  logic [7:0] exp_b [0:139];
  int         exp_n;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_win(input string req, input int w);
    int bad;
    bad = -1;
    checks++;
    if (w >= wcount || w >= 16) begin
      errors++;
      $display("FAIL %s window %0d missing actual=%0d expected=%0d", req, w, wcount, w + 1);
    end else if (wl[w] != exp_n) begin
      errors++;
      $display("FAIL %s window %0d length actual=%0d expected=%0d", req, w, wl[w], exp_n);
    end else begin
      for (int i = 0; i < exp_n; i++)
        if (bad < 0 && wb[w][i] !== exp_b[i]) bad = i;
      if (bad >= 0) begin
        errors++;
        $display("FAIL %s window %0d byte %0d actual=%0h expected=%0h",
                 req, w, bad, wb[w][bad], exp_b[bad]);
      end
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] v;
    int ok;
    ok = 0;
    for (int i = 0; i < 30000; i++) begin
      rd(3'd0, v);
      if (v[4] == 1'b0) begin ok = 1; break; end
    end
    chk(req, "start bit self-clears", 32'(ok), 32'd1);
  endtask

  task automatic wait_stage(input string req, input logic want);
    logic [31:0] v;
    int ok;
    ok = 0;
    for (int i = 0; i < 50; i++) begin
      rd(3'd1, v);
      if (v[0] == want) begin ok = 1; break; end
    end
    chk(req, "staging readback reaches written value", 32'(ok), 32'd1);
  endtask

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 7 + 3) & 8'hFF);
  endfunction

  task automatic set_prog_head(input logic [7:0] op, input logic [31:0] a,
                               input bit four);
    exp_b[0] = op;
    if (four) begin
      exp_b[1] = a[31:24]; exp_b[2] = a[23:16]; exp_b[3] = a[15:8]; exp_b[4] = a[7:0];
      exp_n = 5;
    end else begin
      exp_b[1] = a[23:16]; exp_b[2] = a[15:8]; exp_b[3] = a[7:0];
      exp_n = 4;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1", "cs_n after reset", 32'(spi_cs_n), 32'd1);
    chk("R1", "sck after reset", 32'(spi_sck), 32'd0);
    rd(3'd0, v); chk("R1", "command reg after reset", v, 32'h0);
    rd(3'd1, v); chk("R1", "buffer cfg after reset", v, 32'h0);
  endtask

  task automatic t_single_default;
    logic [31:0] v;
    wcount = 0;
    wr(3'd2, 32'hA0);
    wr(3'd1, 32'h0);
    wr(3'd5, 32'h0);
    wr(3'd4, 32'h0012_3456);
    wr(3'd6, 32'hFFFF_FF5A);
    wr(3'd0, 32'h10);
    rd(3'd0, v); chk("R11", "start bit reads 1 while busy", v, 32'h10);
    wait_idle("R11");
    chk("R12", "one window for program", 32'(wcount), 32'd1);
    set_prog_head(8'h02, 32'h0012_3456, 1'b0);
    exp_b[exp_n] = 8'h5A; exp_n++;
    chk_win("R7", 0);
  endtask

  task automatic t_custom_4b;
    wcount = 0;
    wr(3'd1, 32'h10);
    wr(3'd3, 32'h3E);
    wr(3'd5, 32'h10);
    wr(3'd4, 32'hA1B2_C3D4);
    wr(3'd6, 32'hC7);
    wr(3'd0, 32'h10);
    wait_idle("R8");
    set_prog_head(8'h3E, 32'hA1B2_C3D4, 1'b1);
    exp_b[exp_n] = 8'hC7; exp_n++;
    chk_win("R8", 0);
    wr(3'd1, 32'h0);
    wr(3'd5, 32'h0);
  endtask

  task automatic t_stage_full;
    wcount = 0;
    wr(3'd1, 32'h1);
    wait_stage("R2", 1'b1);
    wr(3'd4, 32'h0000_0400);
    for (int i = 0; i < 32; i++)
      wr(3'd7, {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)});
    wr(3'd7, 32'hDEAD_BEEF);
    wr(3'd7, 32'h1111_1111);
    wr(3'd0, 32'h10);
    wait_idle("R3");
    chk("R12", "one window for staged program", 32'(wcount), 32'd1);
    set_prog_head(8'h02, 32'h0000_0400, 1'b0);
    for (int k = 0; k < 128; k++) begin exp_b[exp_n] = pat(k); exp_n++; end
    chk_win("R3", 0);
    chk("R4", "staged length excludes overflow words", 32'(wl[0]), 32'd132);
  endtask

  task automatic t_partial;
    wcount = 0;
    wr(3'd1, 32'h0);
    wait_stage("R5", 1'b0);
    wr(3'd1, 32'h1);
    wait_stage("R5", 1'b1);
    for (int i = 0; i < 3; i++)
      wr(3'd7, {8'hF0 ^ 8'(4*i+3), 8'hF0 ^ 8'(4*i+2), 8'hF0 ^ 8'(4*i+1), 8'hF0 ^ 8'(4*i)});
    wr(3'd0, 32'h10);
    wait_idle("R6");
    set_prog_head(8'h02, 32'h0000_0400, 1'b0);
    for (int k = 0; k < 12; k++) begin exp_b[exp_n] = 8'hF0 ^ 8'(k); exp_n++; end
    chk_win("R6", 0);
    wr(3'd1, 32'h0);
    wait_stage("R2", 1'b0);
  endtask

  task automatic t_wen_poll;
    logic [31:0] v;
    wcount = 0;
    busy_left = 2;
    wr(3'd2, 32'h0);
    wr(3'd4, 32'h000A_BCDE);
    wr(3'd6, 32'h99);
    wr(3'd0, 32'h10);
    wr(3'd1, 32'h1);
    rd(3'd1, v);
    chk("R2", "staging change held off while busy", 32'(v[0]), 32'd0);
    wr(3'd0, 32'h10);
    wait_idle("R10");
    chk("R10", "window count with two busy polls", 32'(wcount), 32'd5);
    exp_b[0] = 8'h06; exp_n = 1;
    chk_win("R9", 0);
    set_prog_head(8'h02, 32'h000A_BCDE, 1'b0);
    exp_b[exp_n] = 8'h99; exp_n++;
    chk_win("R12", 1);
    for (int w = 2; w < 5; w++) begin
      exp_b[0] = 8'h05; exp_b[1] = 8'h00; exp_n = 2;
      chk_win("R10", w);
    end
    repeat (300) @(negedge clk);
    chk("R11", "start while busy ignored", 32'(wcount), 32'd5);
    wait_stage("R2", 1'b1);
    wr(3'd1, 32'h0);
    wait_stage("R2", 1'b0);
  endtask

  task automatic t_suppress;
    wcount = 0;
    busy_left = 3;
    wr(3'd2, 32'h20);
    wr(3'd0, 32'h10);
    wait_idle("R10");
    chk("R10", "no polling when suppressed", 32'(wcount), 32'd2);
    exp_b[0] = 8'h06; exp_n = 1;
    chk_win("R9", 0);
    wcount = 0;
    busy_left = 1;
    wr(3'd2, 32'h80);
    wr(3'd0, 32'h10);
    wait_idle("R9");
    chk("R9", "no write-enable window when suppressed", 32'(wcount), 32'd3);
    set_prog_head(8'h02, 32'h000A_BCDE, 1'b0);
    exp_b[exp_n] = 8'h99; exp_n++;
    chk_win("R9", 0);
    chk("R12", "sck never high with cs_n high", 32'(sck_bad), 32'd0);
  endtask

  initial begin
    #(8 * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    reg_wr = 1'b0;
    reg_addr = 3'd0;
    reg_wdata = 32'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_single_default();
    t_custom_4b();
    t_stage_full();
    t_partial();
    t_wen_poll();
    t_suppress();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule